// File: doc/BRIEF.md
# Register-Memory Arithmetic Unit

This unit carries out one 16-bit operation between a register operand and a word in byte-wide memory. The six operations are load, store, load address, compare, add and subtract. A word is moved as two byte accesses on a synchronous single-port memory. The more significant byte is at the effective address and the less significant byte is at the next address. Address arithmetic wraps at 16 bits. The result comes back on a register output with a one-cycle write enable. A 2-bit condition code and two carry flags are held in the unit between operations.

One pulse on `start_i` in the idle state captures the operation select, the register operand and the effective address. While the operation runs, `busy_o` is high. One cycle of `done_o` marks completion, following the last memory access. Each class of operation has its own condition-code table, so the meaning of a code depends on which operation wrote it. The memory returns read data one cycle after it sees the address.

Operation select encoding: 0 load, 1 store, 2 load address, 3 compare, 4 add, 5 subtract.

Top module: `regmem_alu`

## Requirements
- R1: Load (select 0) reads the byte at the address as bits 15:8 and the byte at address+1 (modulo 2^16) as bits 7:0. It writes that word to the register output with `reg_we_o` high in the `done_o` cycle.
- R2: Store (select 1) writes operand bits 15:8 at the address and then bits 7:0 at address+1 (modulo 2^16). Memory writes occur only for store.
- R3: Load address (select 2) writes the captured effective address to the register output and performs no memory write.
- R4: Compare (select 3) uses an unsigned comparison and sets the code to 1 for register < memory, 2 for equal and 3 for register > memory. It never produces 0 and does not write the register.
- R5: Add (select 4) writes the 16-bit sum with the carry beyond bit 15 dropped. The code is bit 1 = carry out of bit 15, bit 0 = (sum != 0).
- R6: After add, `carry_hi_o` holds the carry out of bit 15 and `carry_mid_o` holds the carry out of bit 14 (into bit 15).
- R7: Subtract (select 5) writes register minus memory in two's complement. The code is 1 for a negative signed result, 2 for zero and 3 for positive.
- R8: After subtract, `carry_hi_o` is set when register < memory unsigned. `carry_mid_o` is set when the register's low 15 bits are less than memory's low 15 bits.
- R9: Load, store and load address leave the condition code unchanged.
- R10: The carry flags change only on completion of add or subtract and are held otherwise.
- R11: `done_o` is high for exactly one cycle per accepted operation, and `reg_we_o` is high only in that cycle and only for load, load address, add and subtract.
- R12: A start pulse while `busy_o` is high is ignored: it causes no memory access and does not alter the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| op_i | input | 3 | Operation select |
| reg_i | input | 16 | Register operand |
| addr_i | input | 16 | Effective address |
| mem_addr_o | output | 16 | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after address |
| reg_o | output | 16 | Register result |
| reg_we_o | output | 1 | Register write enable |
| cc_o | output | 2 | Condition code |
| carry_hi_o | output | 1 | Carry/borrow out of bit 15 |
| carry_mid_o | output | 1 | Carry/borrow into bit 15 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `mem_rdata_i` comes from a synchronous memory with one cycle of read latency. They also assume that only the six defined select values appear on `op_i` when a start is accepted. The stimulus draws the select from 0 to 5 only. It feeds read data from a bench memory that registers the addressed byte on each clock. After every accepted start, it scrambles the operand, address and select inputs and sometimes pulses start again, which tests that the unit really uses its captured copies.

// File: rtl/regmem_pkg.sv
package regmem_pkg;
  typedef enum logic [2:0] {
    OP_LOAD   = 3'd0,
    OP_STORE  = 3'd1,
    OP_LDADDR = 3'd2,
    OP_CMP    = 3'd3,
    OP_ADD    = 3'd4,
    OP_SUB    = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_HI, S_RD_LO, S_EVAL, S_WR_HI, S_WR_LO, S_FIN
  } state_e;
endpackage

// File: rtl/regmem_seq.sv
module regmem_seq
  import regmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               op_i,
  input  logic [WORD_W-1:0] reg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W/2-1:0] mem_rdata_i,
  output op_e               op_o,
  output logic [WORD_W-1:0] opnd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] word_o,
  output logic              eval_o,
  output logic              fin_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [WORD_W/2-1:0] mem_wdata_o
);
  localparam int BYTE_W = WORD_W / 2;

  state_e            state_q, state_d;
  op_e               op_q;
  logic [WORD_W-1:0] opnd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] hi_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) begin
                 unique case (op_i)
                   OP_STORE:                   state_d = S_WR_HI;
                   OP_LOAD, OP_CMP, OP_ADD, OP_SUB: state_d = S_RD_HI;
                   default:                    state_d = S_EVAL;
                 endcase
               end
      S_RD_HI: state_d = S_RD_LO;
      S_RD_LO: state_d = S_EVAL;
      S_EVAL:  state_d = S_FIN;
      S_WR_HI: state_d = S_WR_LO;
      S_WR_LO: state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_LOAD;
      opnd_q  <= '0;
      addr_q  <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        op_q   <= op_i;
        opnd_q <= reg_i;
        addr_q <= addr_i;
      end
      // high byte arrives the cycle after its address
      if (state_q == S_RD_LO) hi_q <= mem_rdata_i;
    end
  end

  logic lo_phase;
  assign lo_phase    = (state_q == S_RD_LO) || (state_q == S_WR_LO);
  assign mem_addr_o  = lo_phase ? addr_q + ADDR_W'(1) : addr_q;
  assign mem_we_o    = (state_q == S_WR_HI) || (state_q == S_WR_LO);
  assign mem_wdata_o = (state_q == S_WR_LO) ? opnd_q[BYTE_W-1:0] : opnd_q[WORD_W-1:BYTE_W];

  assign op_o   = op_q;
  assign opnd_o = opnd_q;
  assign addr_o = addr_q;
  assign word_o = {hi_q, mem_rdata_i};
  assign eval_o = (state_q == S_EVAL);
  assign fin_o  = (state_q == S_FIN);
  assign busy_o = (state_q != S_IDLE);

  p_write_only_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> op_q == OP_STORE);
  p_busy_start_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(op_q) && $stable(addr_q) && $stable(opnd_q)));
endmodule

// File: rtl/regmem_exec.sv
module regmem_exec
  import regmem_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  op_e               op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] m_i,
  input  logic [WORD_W-1:0] addr_i,
  output logic [WORD_W-1:0] res_o,
  output logic [1:0]        cc_o,
  output logic              reg_wr_o,
  output logic              cc_wr_o,
  output logic              fl_wr_o,
  output logic              c_hi_o,
  output logic              c_mid_o
);
  localparam int LOW_W = WORD_W - 1;

  logic [WORD_W:0]  sum;
  logic [LOW_W:0]   sum_low;
  logic [WORD_W-1:0] diff;

  assign sum     = {1'b0, a_i} + {1'b0, m_i};
  assign sum_low = {1'b0, a_i[LOW_W-1:0]} + {1'b0, m_i[LOW_W-1:0]};
  assign diff    = a_i - m_i;

  always_comb begin
    res_o    = a_i;
    cc_o     = 2'd0;
    reg_wr_o = 1'b0;
    cc_wr_o  = 1'b0;
    fl_wr_o  = 1'b0;
    c_hi_o   = 1'b0;
    c_mid_o  = 1'b0;
    unique case (op_i)
      OP_LOAD: begin
        res_o = m_i; reg_wr_o = 1'b1;
      end
      OP_LDADDR: begin
        res_o = addr_i; reg_wr_o = 1'b1;
      end
      OP_CMP: begin
        cc_wr_o = 1'b1;
        cc_o = (a_i < m_i) ? 2'd1 : (a_i == m_i) ? 2'd2 : 2'd3;
      end
      OP_ADD: begin
        res_o = sum[WORD_W-1:0]; reg_wr_o = 1'b1; cc_wr_o = 1'b1; fl_wr_o = 1'b1;
        c_hi_o  = sum[WORD_W];
        c_mid_o = sum_low[LOW_W];
        cc_o = {sum[WORD_W], |sum[WORD_W-1:0]};
      end
      OP_SUB: begin
        res_o = diff; reg_wr_o = 1'b1; cc_wr_o = 1'b1; fl_wr_o = 1'b1;
        c_hi_o  = a_i < m_i;
        c_mid_o = a_i[LOW_W-1:0] < m_i[LOW_W-1:0];
        cc_o = diff[WORD_W-1] ? 2'd1 : (diff == '0) ? 2'd2 : 2'd3;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regmem_alu.sv
module regmem_alu
  import regmem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [WORD_W-1:0] reg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [WORD_W/2-1:0] mem_wdata_o,
  input  logic [WORD_W/2-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] reg_o,
  output logic              reg_we_o,
  output logic [1:0]        cc_o,
  output logic              carry_hi_o,
  output logic              carry_mid_o,
  output logic              busy_o,
  output logic              done_o
);
  op_e               op_q;
  logic [WORD_W-1:0] opnd, word, res;
  logic [ADDR_W-1:0] addr_q;
  logic              eval, fin;
  logic [1:0]        cc_n;
  logic              reg_wr, cc_wr, fl_wr, c_hi_n, c_mid_n;

  logic [WORD_W-1:0] reg_q;
  logic [1:0]        cc_q;
  logic              c_hi_q, c_mid_q, reg_wr_q;

  regmem_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .op_i        (op_e'(op_i)),
    .reg_i, .addr_i, .mem_rdata_i,
    .op_o        (op_q),
    .opnd_o      (opnd),
    .addr_o      (addr_q),
    .word_o      (word),
    .eval_o      (eval),
    .fin_o       (fin),
    .busy_o,
    .mem_addr_o, .mem_we_o, .mem_wdata_o
  );

  regmem_exec #(.WORD_W(WORD_W)) u_exec (
    .op_i     (op_q),
    .a_i      (opnd),
    .m_i      (word),
    .addr_i   (WORD_W'(addr_q)),
    .res_o    (res),
    .cc_o     (cc_n),
    .reg_wr_o (reg_wr),
    .cc_wr_o  (cc_wr),
    .fl_wr_o  (fl_wr),
    .c_hi_o   (c_hi_n),
    .c_mid_o  (c_mid_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q    <= '0;
      cc_q     <= '0;
      c_hi_q   <= 1'b0;
      c_mid_q  <= 1'b0;
      reg_wr_q <= 1'b0;
    end else if (eval) begin
      reg_wr_q <= reg_wr;
      if (reg_wr) reg_q <= res;
      if (cc_wr)  cc_q  <= cc_n;
      if (fl_wr) begin
        c_hi_q  <= c_hi_n;
        c_mid_q <= c_mid_n;
      end
    end else if (fin) begin
      reg_wr_q <= 1'b0;
    end
  end

  assign reg_o       = reg_q;
  assign cc_o        = cc_q;
  assign carry_hi_o  = c_hi_q;
  assign carry_mid_o = c_mid_q;
  assign done_o      = fin;
  assign reg_we_o    = fin && reg_wr_q;

  p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_reg_we_in_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> done_o);
  p_cmp_code_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_CMP) |-> (cc_o != 2'd0 && !reg_we_o));
  p_cc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_LOAD || op_q == OP_STORE || op_q == OP_LDADDR)) |-> $stable(cc_o));
  p_flag_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && (op_q == OP_ADD || op_q == OP_SUB)) |-> $stable({carry_hi_o, carry_mid_o}));
  p_add_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_ADD) |-> (cc_o[1] == carry_hi_o && cc_o[0] == (reg_o != '0)));
  p_ldaddr_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q == OP_LDADDR) |-> !mem_we_o);
endmodule

// File: tb/regmem_alu_tb.sv
`timescale 1ns/1ps
module regmem_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] reg_in = '0, addr_in = '0;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] reg_out;
  logic        reg_we, c_hi, c_mid, busy, done;
  logic [1:0]  cc;

  int n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  regmem_alu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .reg_i(reg_in),
    .addr_i(addr_in), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .reg_o(reg_out),
    .reg_we_o(reg_we), .cc_o(cc), .carry_hi_o(c_hi), .carry_mid_o(c_mid),
    .busy_o(busy), .done_o(done)
  );

  // bench byte memory, indexed by the low address byte
  logic [7:0]  ram [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_a = '0, poke_d = '0;
  int          wr_cnt = 0;
  logic [15:0] wa_last = '0, wa_prev = '0;

  always @(posedge clk) begin
    if (poke_en) ram[poke_a] <= poke_d;
    else if (mem_we) begin
      ram[mem_addr[7:0]] <= mem_wdata;
      wr_cnt  <= wr_cnt + 1;
      wa_prev <= wa_last;
      wa_last <= mem_addr;
    end
    mem_rdata <= ram[mem_addr[7:0]];
  end

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 1'b0;
  endtask

  task automatic poke_word(input logic [15:0] a, input logic [15:0] w);
    poke(a[7:0], w[15:8]);
    poke(8'(a[7:0] + 8'd1), w[7:0]);
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench model state
  logic [1:0]  m_cc = 2'd0;
  logic        m_hi = 1'b0, m_mid = 1'b0;
  logic [15:0] m_reg = '0;

  function automatic logic [1:0] f_cmp(input logic [15:0] r, input logic [15:0] m);
    int ri = int'(r), mi = int'(m);
    if (ri < mi) return 2'd1;
    if (ri == mi) return 2'd2;
    return 2'd3;
  endfunction

  task automatic run_op(input logic [2:0] o, input logic [15:0] r, input logic [15:0] a, input bit kick);
    logic [15:0] m, res;
    logic        wr_reg;
    int          w0, s, lo, k;
    string       tag;
    m = {ram[a[7:0]], ram[8'(a[7:0] + 8'd1)]};
    wr_reg = 1'b0; res = m_reg;
    case (o)
      3'd0: begin tag = "R1"; res = m; wr_reg = 1'b1; end
      3'd1: tag = "R2";
      3'd2: begin tag = "R3"; res = a; wr_reg = 1'b1; end
      3'd3: begin tag = "R4"; m_cc = f_cmp(r, m); end
      3'd4: begin
        tag = "R5";
        s = int'(r) + int'(m);
        lo = int'(r % 16'h8000) + int'(m % 16'h8000);
        res = 16'(s); wr_reg = 1'b1;
        m_hi = (s > 65535); m_mid = (lo > 32767);
        m_cc = {m_hi, res != 16'd0};
      end
      default: begin
        tag = "R7";
        s = int'($signed(r)) - int'($signed(m));
        res = 16'(s); wr_reg = 1'b1;
        m_hi = int'(r) < int'(m); m_mid = int'(r % 16'h8000) < int'(m % 16'h8000);
        m_cc = $signed(res) < 0 ? 2'd1 : (res == 16'd0 ? 2'd2 : 2'd3);
      end
    endcase
    w0 = wr_cnt;
    @(negedge clk); start = 1'b1; op = o; reg_in = r; addr_in = a;
    @(negedge clk); start = 1'b0; op = 3'($urandom_range(0, 5)); reg_in = 16'($urandom); addr_in = 16'($urandom);
    if (kick && o != 3'd2) begin
      // R12: second start while busy, with store selected
      start = 1'b1; op = 3'd1;
      @(negedge clk); start = 1'b0;
    end
    k = 0;
    while (!done && k < 20) begin @(negedge clk); k++; end
    check("R11", "done seen", {31'd0, done}, 32'd1);
    check("R11", "reg_we", {31'd0, reg_we}, {31'd0, wr_reg});
    if (wr_reg) m_reg = res;
    check(tag, "reg_o", {16'd0, reg_out}, {16'd0, m_reg});
    check(o == 3'd3 ? "R4" : (o >= 3'd4 ? tag : "R9"), "cc", {30'd0, cc}, {30'd0, m_cc});
    check(o >= 3'd4 ? (o == 3'd4 ? "R6" : "R8") : "R10", "flags",
          {30'd0, c_hi, c_mid}, {30'd0, m_hi, m_mid});
    if (o == 3'd1) begin
      check("R2", "write count", wr_cnt, w0 + 2);
      check("R2", "hi addr", {16'd0, wa_prev}, {16'd0, a});
      check("R2", "lo addr", {16'd0, wa_last}, {16'd0, 16'(a + 16'd1)});
      check("R2", "stored word", {16'd0, ram[a[7:0]], ram[8'(a[7:0] + 8'd1)]}, {16'd0, r});
    end else begin
      check(kick ? "R12" : "R3", "no write", wr_cnt, w0);
    end
    @(negedge clk);
    check("R11", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R11", "reset done", {31'd0, done}, 32'd0);
    check("R10", "reset flags/cc", {28'd0, busy, cc, c_hi}, 32'd0);
    check("R2", "reset we", {31'd0, mem_we}, 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) poke(8'(i), 8'($urandom));

    // R1 wrap across top of address space
    poke_word(16'hFFFF, 16'hA55A);
    run_op(3'd0, 16'h0000, 16'hFFFF, 1'b0);
    poke_word(16'h1234, 16'hBEEF);
    run_op(3'd0, 16'h0000, 16'h1234, 1'b1);
    // R2 store with wrap
    run_op(3'd1, 16'hC3A7, 16'hFFFF, 1'b0);
    run_op(3'd1, 16'h0102, 16'h0040, 1'b1);
    // R3
    run_op(3'd2, 16'h9999, 16'hFEDC, 1'b0);
    // R4 compare corners
    poke_word(16'h0010, 16'h0001);
    run_op(3'd3, 16'hFFFF, 16'h0010, 1'b0);
    run_op(3'd3, 16'h0001, 16'h0010, 1'b0);
    run_op(3'd3, 16'h0000, 16'h0010, 1'b1);
    // R5/R6 add corners
    run_op(3'd4, 16'hFFFF, 16'h0010, 1'b0);
    poke_word(16'h0020, 16'h8000);
    run_op(3'd4, 16'h8000, 16'h0020, 1'b0);
    run_op(3'd4, 16'h7FFF, 16'h0010, 1'b0);
    // R7/R8 subtract corners
    run_op(3'd5, 16'h0001, 16'h0010, 1'b0);
    poke_word(16'h0030, 16'h0002);
    run_op(3'd5, 16'h0001, 16'h0030, 1'b0);
    run_op(3'd5, 16'h8000, 16'h0010, 1'b1);
    // R9/R10 hold after arithmetic
    run_op(3'd0, 16'h0000, 16'h0030, 1'b0);
    run_op(3'd2, 16'h0000, 16'h0007, 1'b0);

    for (int i = 0; i < 400; i++)
      run_op(3'($urandom_range(0, 5)), 16'($urandom), 16'($urandom), 1'($urandom));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule